// File: doc/BRIEF.md
# Multi-mode system clock divider

This block produces the system clock for a processor subsystem. In normal operation the system clock is the fast main oscillator clock divided by a selectable integer ratio, including the odd ratio 3. Two further modes take the system clock from the slow sub oscillator instead: a low-speed mode in which the main oscillator keeps running, and a low-power mode in which the block drops its main-oscillator enable. A stop request parks the clock low and shuts the main oscillator down. The block returns to divide-by-8 whenever the main clock goes away.

Software selects the ratio by writing a ratio register and selects the clock source by writing a mode register, both through one write port. Changes that need a settled oscillator wait for the matching stable flag. Ratio changes wait for the end of the running output period. Source changes pass through a phase in which the output is held low, so the system clock never carries a shortened pulse. The control logic runs on the main clock input, which is taken to be free-running at the block boundary. The sub clock is sampled through a two-flop synchronizer and must be at least six main periods long. A status output reports the mode in force and the ratio being applied.

Top module: `sysclk_gen`

## Requirements
- R1: After reset, mode_o is 0 (main), ratio_o is 8, main_osc_en is 1, and sysclk has a period of 8 main-clock periods with a high phase of 4.
- R2: A write with wr_sel=0 and wr_data equal to N, for N in {1,2,3,4,6,8,10,12,14,16}, selects ratio N. The sysclk period is then N main periods, the high phase is floor(N/2) periods and the rest is low, so divide-by-3 gives 1 high and 2 low. For N=1, sysclk follows the main clock and ratio_o reads N.
- R3: A ratio write whose code is not in that set (for example 0, 5, 7, 17, 48 or 0x88) leaves ratio_o and the sysclk period unchanged.
- R4: A new ratio takes effect only when the current output period ends. Every high and every low phase around a change is a whole phase of either the old ratio or the new one.
- R5: While the applied ratio is 8 and main_stable is low, a write of another ratio is held off and ratio_o stays 8. The held ratio is applied once main_stable rises.
- R6: A write with wr_sel=1 sets the requested mode from wr_data: 0 main, 1 low-speed, 2 low-power. Code 3 and larger values are ignored. In low-speed mode, mode_o is 1, main_osc_en is 1, and sysclk follows the sub clock with its period and high time.
- R7: A change from main to a sub-clock mode, or from a sub-clock mode back to main, happens only while both main_stable and sub_stable are high. Until then mode_o keeps its old value.
- R8: In low-power mode, mode_o is 2, main_osc_en is 0 and sysclk follows the sub clock. The ratio register is forced to 8, so ratio_o reads 8 and a later return to main runs at divide-by-8.
- R9: While stop_req is high, the block ends its current output phase and then reports mode_o 3, holds sysclk low and drives main_osc_en to 0. The ratio register is forced to 8 and the mode request is cleared to main. After release and main_stable, the block resumes in main mode at divide-by-8.
- R10: When the clock source changes, no high phase is shorter than the shorter high phase of the two sources. The output stays low for at least HOLD_CYC+1 main periods before the divided clock restarts. mode_o is 4 during the handoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main oscillator clock; clocks all control logic |
| clk_sub | input | 1 | Slow sub oscillator clock, sampled as data |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 ratio register, 1 mode register |
| wr_data | input | 8 | Write value |
| main_stable | input | 1 | Main oscillator reported stable |
| sub_stable | input | 1 | Sub oscillator reported stable |
| stop_req | input | 1 | Stop-mode request |
| sysclk | output | 1 | Generated system clock |
| main_osc_en | output | 1 | Enable for the main oscillator |
| mode_o | output | 3 | Active mode: 0 main, 1 low-speed, 2 low-power, 3 stop, 4 handoff |
| ratio_o | output | 5 | Ratio currently applied by the divider |

## Verification
A wrong divider count or a wrong applied ratio shows up as a wrong period or a wrong high time on sysclk within one output period, at most 16 main cycles. A sequencer stuck in the wrong state shows up in mode_o and main_osc_en as soon as the oscillator-stable flags allow the move, within about one sub-clock period. A ratio register that misses a forced reload is not visible while the block runs from the sub clock. It appears only after the return to main mode, as a period other than 8 cycles. A handoff that skips its low hold, or applies a ratio mid-period, leaves a short pulse on sysclk that a pulse-width monitor catches in the same cycle.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;

    localparam int DATA_W    = 8;
    localparam int RATIO_W   = 5;
    localparam int RATIO_RST = 8;
    localparam int RATIO_MAX = 16;

    typedef enum logic [2:0] {
        ST_MAIN,
        ST_PARK,
        ST_SUB,
        ST_HOLD,
        ST_WAKE,
        ST_STOP
    } seq_st_e;

    typedef enum logic [2:0] {
        MD_MAIN     = 3'd0,
        MD_LOWSPEED = 3'd1,
        MD_LOWPOWER = 3'd2,
        MD_STOP     = 3'd3,
        MD_SWITCH   = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        REQ_MAIN     = 2'd0,
        REQ_LOWSPEED = 2'd1,
        REQ_LOWPOWER = 2'd2
    } req_e;

    // Legal codes equal their ratio: 1..4, then even values up to RATIO_MAX.
    function automatic logic ratio_ok(input logic [DATA_W-1:0] code);
        return (code >= 1) && (code <= DATA_W'(RATIO_MAX)) &&
               ((code <= 4) || !code[0]);
    endfunction

    function automatic logic mode_code_ok(input logic [DATA_W-1:0] code);
        return code <= 2;
    endfunction

endpackage

// File: rtl/sysclk_regs.sv
`timescale 1ns/1ps
module sysclk_regs
    import sysclk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  force_dflt,
    input  logic                  clear_mode,
    output logic [RATIO_W-1:0]    div_code,
    output req_e                  mode_req
);

    always_ff @(posedge clk) begin
        if (rst || force_dflt) begin
            div_code <= RATIO_W'(RATIO_RST);
        end else if (wr_en && !wr_sel && ratio_ok(wr_data)) begin
            div_code <= wr_data[RATIO_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_mode) begin
            mode_req <= REQ_MAIN;
        end else if (wr_en && wr_sel && mode_code_ok(wr_data)) begin
            mode_req <= req_e'(wr_data[1:0]);
        end
    end

    // R8
    forced_reload_chk: assert property (@(posedge clk) disable iff (rst)
        force_dflt |=> (div_code == RATIO_W'(RATIO_RST)));

endmodule

// File: rtl/sysclk_sync.sv
`timescale 1ns/1ps
module sysclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sysclk_seq.sv
`timescale 1ns/1ps
module sysclk_seq
    import sysclk_pkg::*;
#(
    parameter int HOLD_CYC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stop_req,
    input  logic               main_stable,
    input  logic               sub_stable,
    input  logic               sub_lvl,
    input  logic [RATIO_W-1:0] div_code,
    input  req_e               mode_req,
    output logic               lvl_d,
    output logic               direct_en,
    output logic               osc_en,
    output mode_e              mode,
    output logic [RATIO_W-1:0] ratio
);

    localparam int MAXC = ((1 << RATIO_W) > HOLD_CYC) ? (1 << RATIO_W) : HOLD_CYC + 1;
    localparam int CW   = $clog2(MAXC);

    seq_st_e            st, st_n;
    logic [CW-1:0]      cnt, cnt_n;
    logic [RATIO_W-1:0] cur, cur_n, target;
    logic               wrap, want_sub, both_ok;

    assign wrap     = (cnt == CW'(cur) - CW'(1));
    assign both_ok  = main_stable && sub_stable;
    assign want_sub = (mode_req != REQ_MAIN) && both_ok;
    assign target   = ((div_code == RATIO_W'(RATIO_RST)) ||
                       (cur != RATIO_W'(RATIO_RST)) || main_stable)
                      ? div_code : RATIO_W'(RATIO_RST);
    assign osc_en   = !((st == ST_STOP) ||
                        ((st == ST_SUB) && (mode_req == REQ_LOWPOWER)));

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        cur_n = cur;
        case (st)
            ST_MAIN: begin
                if (wrap) begin
                    cnt_n = '0;
                    if (stop_req || want_sub) st_n = ST_PARK;
                    else                      cur_n = target;
                end else begin
                    cnt_n = cnt + CW'(1);
                end
            end
            ST_PARK: begin
                if (stop_req) begin
                    st_n = ST_STOP;
                end else if (!want_sub) begin
                    st_n  = ST_HOLD;
                    cnt_n = '0;
                end else if (!sub_lvl) begin
                    st_n = ST_SUB;
                end
            end
            ST_SUB: begin
                if (stop_req && !sub_lvl) begin
                    st_n = ST_STOP;
                end else if ((mode_req == REQ_MAIN) && both_ok && !sub_lvl) begin
                    st_n  = ST_HOLD;
                    cnt_n = '0;
                end
            end
            ST_HOLD: begin
                if (stop_req) begin
                    st_n = ST_STOP;
                end else if (cnt == CW'(HOLD_CYC - 1)) begin
                    st_n  = ST_MAIN;
                    cnt_n = '0;
                    cur_n = target;
                end else begin
                    cnt_n = cnt + CW'(1);
                end
            end
            ST_WAKE: begin
                if (stop_req) begin
                    st_n = ST_STOP;
                end else if (main_stable) begin
                    st_n  = ST_HOLD;
                    cnt_n = '0;
                end
            end
            ST_STOP: begin
                if (!stop_req) st_n = ST_WAKE;
            end
            default: st_n = ST_MAIN;
        endcase
        if (!osc_en || (st == ST_STOP)) cur_n = RATIO_W'(RATIO_RST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_MAIN;
            cnt <= '0;
            cur <= RATIO_W'(RATIO_RST);
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            cur <= cur_n;
        end
    end

    assign lvl_d = ((st == ST_MAIN) && (cnt < CW'(cur >> 1))) ||
                   ((st == ST_SUB) && sub_lvl);
    assign direct_en = (st == ST_MAIN) && (cur == RATIO_W'(1));

    always_comb begin
        case (st)
            ST_MAIN: mode = MD_MAIN;
            ST_SUB:  mode = osc_en ? MD_LOWSPEED : MD_LOWPOWER;
            ST_STOP: mode = MD_STOP;
            default: mode = MD_SWITCH;
        endcase
    end

    assign ratio = cur;

    // R2
    ratio_legal_chk: assert property (@(posedge clk) disable iff (rst)
        ratio_ok(DATA_W'(cur)));

    // R4
    ratio_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_MAIN) && ($past(st) == ST_MAIN) && (cur != $past(cur)))
        |-> ($past(cnt) == CW'($past(cur)) - CW'(1)));

    // R5
    hold_div8_chk: assert property (@(posedge clk) disable iff (rst)
        ((cur == RATIO_W'(RATIO_RST)) && !main_stable) |=> (cur == RATIO_W'(RATIO_RST)));

endmodule

// File: rtl/sysclk_out.sv
`timescale 1ns/1ps
module sysclk_out (
    input  logic clk,
    input  logic rst,
    input  logic lvl_d,
    input  logic direct_en,
    output logic sysclk
);

    logic lvl_q;
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_d;
    end

    // Gate updated while clk is low, so the direct path never slices a pulse.
    always_ff @(negedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= direct_en;
    end

    assign sysclk = lvl_q | (clk & gate_q);

    // R2
    path_excl_chk: assert property (@(posedge clk) disable iff (rst)
        gate_q |-> !lvl_q);

endmodule

// File: rtl/sysclk_gen.sv
`timescale 1ns/1ps
module sysclk_gen
    import sysclk_pkg::*;
#(
    parameter int HOLD_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_main,
    input  logic              clk_sub,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              main_stable,
    input  logic              sub_stable,
    input  logic              stop_req,
    output logic              sysclk,
    output logic              main_osc_en,
    output logic [2:0]        mode_o,
    output logic [RATIO_W-1:0] ratio_o
);

    logic [RATIO_W-1:0] div_code;
    req_e               mode_req;
    mode_e              mode;
    logic               sub_lvl, lvl_d, direct_en, osc_en;

    sysclk_regs u_regs (
        .clk        (clk_main),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .force_dflt (stop_req || !osc_en),
        .clear_mode (stop_req),
        .div_code   (div_code),
        .mode_req   (mode_req)
    );

    sysclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk_main),
        .rst (rst),
        .d   (clk_sub),
        .q   (sub_lvl)
    );

    sysclk_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk         (clk_main),
        .rst         (rst),
        .stop_req    (stop_req),
        .main_stable (main_stable),
        .sub_stable  (sub_stable),
        .sub_lvl     (sub_lvl),
        .div_code    (div_code),
        .mode_req    (mode_req),
        .lvl_d       (lvl_d),
        .direct_en   (direct_en),
        .osc_en      (osc_en),
        .mode        (mode),
        .ratio       (ratio_o)
    );

    sysclk_out u_out (
        .clk       (clk_main),
        .rst       (rst),
        .lvl_d     (lvl_d),
        .direct_en (direct_en),
        .sysclk    (sysclk)
    );

    assign main_osc_en = osc_en;
    assign mode_o      = mode;

    // R9
    stop_settled_chk: assert property (@(posedge clk_main) disable iff (rst)
        ((mode_o == MD_STOP) && ($past(mode_o) == MD_STOP))
        |-> (!main_osc_en && (ratio_o == RATIO_W'(RATIO_RST))));

endmodule

// File: tb/sysclk_gen_tb.sv
`timescale 1ns/1ps
module sysclk_gen_tb;

    logic       clk_main = 1'b0;
    logic       clk_sub  = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sub_stable = 1'b0, stop_req = 1'b0, ms_allow = 1'b0;
    logic       main_stable;
    wire        sysclk, main_osc_en;
    wire [2:0]  mode_o;
    wire [4:0]  ratio_o;

    int n_chk = 0, n_bad = 0, osc_cnt = 0;
    real t_r = -1.0, t_f = -1.0, arm_t = 0.0, min_hi = 1.0e9, min_lo = 1.0e9;
    logic mon_arm = 1'b0;

    always #4 clk_main = ~clk_main;
    initial begin #3; forever #80 clk_sub = ~clk_sub; end

    // Oscillator model: stable 10 cycles after the enable rises.
    always @(negedge clk_main) begin
        if (!main_osc_en) osc_cnt <= 0;
        else if (osc_cnt < 10) osc_cnt <= osc_cnt + 1;
    end
    assign main_stable = ms_allow && (osc_cnt >= 10);

    sysclk_gen u_dut (
        .clk_main(clk_main), .clk_sub(clk_sub), .rst(rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .main_stable(main_stable), .sub_stable(sub_stable), .stop_req(stop_req),
        .sysclk(sysclk), .main_osc_en(main_osc_en), .mode_o(mode_o), .ratio_o(ratio_o)
    );

    // Pulse-width monitor over an armed window.
    always @(posedge sysclk) begin
        if (mon_arm && t_f >= arm_t && ($realtime - t_f) < min_lo) min_lo = $realtime - t_f;
        t_r = $realtime;
    end
    always @(negedge sysclk) begin
        if (mon_arm && t_r >= arm_t && ($realtime - t_r) < min_hi) min_hi = $realtime - t_r;
        t_f = $realtime;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input string what, input int act, input int lim);
        n_chk++;
        if (act < lim) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_main);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk_main);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk_main);
        wr_en = 1'b0;
    endtask

    task automatic measure(output int hi, output int per);
        real a, b, c;
        @(posedge sysclk); a = $realtime;
        @(negedge sysclk); b = $realtime;
        @(posedge sysclk); c = $realtime;
        hi  = $rtoi(b - a + 0.5);
        per = $rtoi(c - a + 0.5);
    endtask

    task automatic chk_wave(input string req, input int hi_exp, input int per_exp);
        int hi, per;
        measure(hi, per);
        chk(req, "high ns", hi, hi_exp);
        chk(req, "period ns", per, per_exp);
    endtask

    task automatic t_reset();
        cyc(4); rst = 1'b0; cyc(3);
        chk("R1", "mode", int'(mode_o), 0);
        chk("R1", "ratio", int'(ratio_o), 8);
        chk("R1", "osc_en", int'(main_osc_en), 1);
        chk_wave("R1", 32, 64);
    endtask

    task automatic t_holdoff();
        wr(1'b0, 8'd2); cyc(50);
        chk("R5", "ratio held", int'(ratio_o), 8);
        chk_wave("R5", 32, 64);
        ms_allow = 1'b1; cyc(50);
        chk("R5", "ratio after stable", int'(ratio_o), 2);
        chk_wave("R5", 8, 16);
    endtask

    task automatic t_sweep();
        int rl[10] = '{1, 2, 3, 4, 6, 8, 10, 12, 14, 16};
        for (int i = 0; i < 10; i++) begin
            wr(1'b0, 8'(rl[i])); cyc(40);
            chk("R2", "ratio", int'(ratio_o), rl[i]);
            chk_wave("R2", (rl[i] == 1) ? 4 : (rl[i] / 2) * 8, rl[i] * 8);
        end
    endtask

    task automatic t_badcode();
        int bad[6] = '{0, 5, 7, 17, 48, 136};
        for (int i = 0; i < 6; i++) begin
            wr(1'b0, 8'(bad[i])); cyc(4);
            chk("R3", "ratio unchanged", int'(ratio_o), 16);
        end
        chk_wave("R3", 64, 128);
    endtask

    task automatic t_boundary();
        real tp;
        int w;
        @(posedge sysclk); #20;
        wr(1'b0, 8'd2);
        @(negedge sysclk); tp = $realtime;
        for (int i = 0; i < 6; i++) begin
            @(posedge sysclk); w = $rtoi($realtime - tp + 0.5); tp = $realtime;
            chk("R4", "low phase whole", int'((w == 8) || (w == 64)), 1);
            @(negedge sysclk); w = $rtoi($realtime - tp + 0.5); tp = $realtime;
            chk("R4", "high phase whole", int'((w == 8) || (w == 64)), 1);
        end
        chk_wave("R4", 8, 16);
    endtask

    task automatic t_lowspeed();
        wr(1'b0, 8'd8); cyc(40);
        wr(1'b1, 8'd1); cyc(100);
        chk("R7", "mode waits for sub_stable", int'(mode_o), 0);
        arm_t = $realtime; min_hi = 1.0e9; min_lo = 1.0e9; mon_arm = 1'b1;
        sub_stable = 1'b1; cyc(100);
        chk("R6", "mode low-speed", int'(mode_o), 1);
        chk("R6", "osc_en", int'(main_osc_en), 1);
        chk_wave("R6", 80, 160);
        sub_stable = 1'b0;
        wr(1'b1, 8'd0); cyc(100);
        chk("R7", "exit waits for sub_stable", int'(mode_o), 1);
        sub_stable = 1'b1; cyc(100);
        chk("R7", "back in main", int'(mode_o), 0);
        chk_wave("R7", 32, 64);
        mon_arm = 1'b0;
        chk_ge("R10", "min high ns", $rtoi(min_hi + 0.5), 32);
        chk_ge("R10", "min low ns", $rtoi(min_lo + 0.5), 24);
        wr(1'b1, 8'd3); cyc(100);
        chk("R6", "code 3 ignored", int'(mode_o), 0);
        chk("R6", "code 3 osc_en", int'(main_osc_en), 1);
    endtask

    task automatic t_lowpower();
        bit seen_sw = 0;
        wr(1'b0, 8'd4); cyc(40);
        chk("R8", "ratio before", int'(ratio_o), 4);
        wr(1'b1, 8'd2);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk_main);
            if (mode_o == 3'd4) seen_sw = 1;
        end
        chk("R10", "handoff reported", int'(seen_sw), 1);
        chk("R8", "mode low-power", int'(mode_o), 2);
        chk("R8", "osc_en off", int'(main_osc_en), 0);
        chk("R8", "ratio forced", int'(ratio_o), 8);
        chk_wave("R8", 80, 160);
        wr(1'b1, 8'd0); cyc(4);
        chk("R8", "osc_en back on", int'(main_osc_en), 1);
        cyc(100);
        chk("R8", "mode main", int'(mode_o), 0);
        chk("R8", "ratio after return", int'(ratio_o), 8);
        chk_wave("R8", 32, 64);
    endtask

    task automatic t_stop();
        int highs = 0;
        wr(1'b0, 8'd4); cyc(40);
        @(negedge clk_main); stop_req = 1'b1;
        cyc(20);
        chk("R9", "mode stop", int'(mode_o), 3);
        chk("R9", "osc_en off", int'(main_osc_en), 0);
        chk("R9", "ratio forced", int'(ratio_o), 8);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_main); #2;
            if (sysclk) highs++;
        end
        chk("R9", "sysclk held low", highs, 0);
        @(negedge clk_main); stop_req = 1'b0;
        cyc(80);
        chk("R9", "mode main after stop", int'(mode_o), 0);
        chk("R9", "ratio after stop", int'(ratio_o), 8);
        chk_wave("R9", 32, 64);
    endtask

    initial begin
        t_reset();
        t_holdoff();
        t_sweep();
        t_badcode();
        t_boundary();
        t_lowspeed();
        t_lowpower();
        t_stop();
        summary();
    end

endmodule